// File: doc/BRIEF.md
# Cascaded Codec Serial Frame Interpreter

This block sits behind the synchronous serial port of a codec that may be one of several chained in a daisy-chain to a host signal processor. It assembles each incoming 16-bit frame from a serial data line and a frame sync. It then decides, from the current operating mode, whether the frame is a control word or a converter sample. For every frame it hands exactly one 16-bit word to its own serial transmitter. That word is a control word passed further down the chain, a data frame that belongs to another device, or the local ADC sample.

Control words carry a 3-bit address. The address is decremented on each hop, and the device that sees zero takes the word. In data mode the block picks its own DAC sample by counting data frames against a programmable device count. In mixed mode the frame MSB separates control words from samples, so settings can be changed while audio keeps flowing. A small register file holds the settings. Register 0 holds the mode bits and the device count.

Top module: `codec_frame_if`

## Requirements
- R1: After a synchronous active-low reset: `op_mode` = 0 (program), register 0 = 8'h10 (device count 1), every other register = 0, `dac_word` = 0, and `dac_load`, `ser_out`, `fs_out` are low.
- R2: In program mode (register 0 bit 0 = 0) every frame is a control word: bits 14:12 address, bits 11:8 register index, bits 7:0 value, with bit 15 ignored. When the address is 0, the value is written to the indexed register and the outgoing word is the ADC word.
- R3: A control word with a nonzero address is sent out with its address reduced by one and all other bits unchanged. It writes no register.
- R4: A control write whose index is not below NREG (8) changes no register.
- R5: Writing register 0 with bit 0 = 1 and bit 1 = 0 enters data mode (`op_mode` = 1). From then on every frame is data, and no frame changes any register until reset.
- R6: In data and mixed modes, data frames are counted starting at 1. The frame whose number equals the device count is loaded into `dac_word`, its outgoing word is the ADC word, and the count restarts at 1. Every other data frame is passed out unchanged.
- R7: The device count is register 0 bits 6:4, with value 0 meaning 8. Any write to register 0 restarts the data frame count at 1.
- R8: In mixed mode (register 0 bits 1:0 = 2'b11, `op_mode` = 2), a frame with bit 15 = 1 is a control word and a frame with bit 15 = 0 is data. A selected data frame loads {bits 14:0, 1'b0}. Every ADC word sent out has bit 15 forced to 0.
- R9: Mixed mode can be entered straight from program mode with one control write. A mixed-mode write that clears register 0 bit 0 returns to program mode.
- R10: The ADC word is sampled with the frame sync. The outgoing frame starts with `fs_out` high and its MSB on `ser_out` 17 cycles after the frame sync is sampled, and then shifts out MSB first. A DAC load pulses `dac_load` for one cycle in that same cycle.
- R11: Frames may follow back to back with no idle cycle, and every frame is still interpreted and answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data in, MSB first |
| fs_in | input | 1 | Frame sync, high with the MSB |
| adc_word | input | 16 | Local ADC sample, taken at frame sync |
| ser_out | output | 1 | Serial data out, MSB first |
| fs_out | output | 1 | Outgoing frame sync, high with the MSB |
| dac_word | output | 16 | DAC register |
| dac_load | output | 1 | One-cycle pulse on a DAC update |
| op_mode | output | 2 | 0 program, 1 data, 2 mixed |
| cfg_flat | output | 64 | Register file, register i at bits 8i+7:8i |

## Verification
With frames sent back to back, the decision on one frame falls in the same cycle that the next frame's sync and MSB arrive. In that cycle the transmitter also reloads just as the last bit of its previous word leaves. Random mixed-mode traffic and directed device-count runs are sent with no idle gap between frames. A bench model predicts the outgoing words, the DAC loads and the register file. The captured serial output and DAC updates are then compared word by word, so a frame lost or merged at that boundary shows up as a count or value mismatch.

// File: rtl/codec_fi_pkg.sv
// Shared types and helpers for the codec frame interpreter.
// Assumes 16-bit frames and a 3-bit cascade address.
package codec_fi_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W = 3;
    localparam int MAX_DEV = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;
    localparam logic [7:0] CRA_RESET = 8'h10;

    typedef enum logic [1:0] {
        MODE_PGM  = 2'd0,
        MODE_DATA = 2'd1,
        MODE_MIX  = 2'd2
    } op_mode_e;

    typedef struct packed {
        logic              flag;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        idx;
        logic [7:0]        val;
    } ctl_word_t;

    // Operating mode from the two low bits of register 0.
    function automatic op_mode_e mode_of(input logic [7:0] cra);
        if (!cra[0]) return MODE_PGM;
        else if (cra[1]) return MODE_MIX;
        else return MODE_DATA;
    endfunction

    // Device count from register 0 bits 6:4, zero meaning the full chain.
    function automatic logic [CNT_W-1:0] dev_count_of(input logic [7:0] cra);
        logic [ADDR_W-1:0] f;
        f = cra[4 +: ADDR_W];
        return (f == '0) ? CNT_W'(MAX_DEV) : {1'b0, f};
    endfunction
endpackage

// File: rtl/codec_fi_rx.sv
// Serial frame receiver: collects FRAME_W bits, MSB first, starting at
// the bit that carries the frame sync; pulses frame_done one cycle after
// the last bit. Assumes frames are at least FRAME_W cycles apart; a new
// sync restarts collection. Samples the ADC word with the sync.
module codec_fi_rx import codec_fi_pkg::*; #(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          fs_in,
    input  logic [FW-1:0] adc_in,
    output logic          frame_done,
    output logic [FW-1:0] frame_word,
    output logic [FW-1:0] adc_held
);
    localparam int BW = $clog2(FW);

    logic [BW-1:0] bcnt;
    logic          active;

    // Shift in bits, count them and flag the completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt       <= '0;
            active     <= 1'b0;
            frame_done <= 1'b0;
            frame_word <= '0;
            adc_held   <= '0;
        end else begin
            frame_done <= 1'b0;
            if (fs_in) begin
                frame_word <= {frame_word[FW-2:0], ser_in};
                bcnt       <= BW'(1);
                active     <= 1'b1;
                adc_held   <= adc_in;
            end else if (active) begin
                frame_word <= {frame_word[FW-2:0], ser_in};
                if (bcnt == BW'(FW - 1)) begin
                    active     <= 1'b0;
                    frame_done <= 1'b1;
                    bcnt       <= '0;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // R11: completion is a single-cycle event even with back-to-back frames
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/codec_fi_decode.sv
// Frame decision: classifies each completed frame by mode, handles cascade
// addressing, writes the register file, counts data frames against the
// device count and loads the DAC register. Produces the outgoing word
// combinationally in the completion cycle. Assumes frame_done pulses.
module codec_fi_decode import codec_fi_pkg::*; #(
    parameter int NREG = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_done,
    input  logic [FRAME_W-1:0]   frame_word,
    input  logic [FRAME_W-1:0]   adc_word,
    output logic                 tx_load,
    output logic [FRAME_W-1:0]   tx_word,
    output logic                 dac_load,
    output logic [FRAME_W-1:0]   dac_word,
    output logic [1:0]           op_mode,
    output logic [NREG*8-1:0]    cfg_flat
);
    logic [7:0]       regs [NREG];
    logic [CNT_W-1:0] fcnt;
    logic [CNT_W-1:0] dev_n;
    op_mode_e         mode;
    ctl_word_t        ctl;
    logic             is_ctl, for_me, idx_ok, wr_hit, own_data;
    logic [FRAME_W-1:0] adc_fmt, dac_next;

    // Field view, mode and device count of the current state.
    always_comb begin
        ctl      = ctl_word_t'(frame_word);
        mode     = mode_of(regs[0]);
        dev_n    = dev_count_of(regs[0]);
        is_ctl   = (mode == MODE_PGM) || ((mode == MODE_MIX) && ctl.flag);
        for_me   = is_ctl && (ctl.addr == '0);
        idx_ok   = ({28'd0, ctl.idx} < NREG);
        wr_hit   = frame_done && for_me && idx_ok;
        own_data = !is_ctl && (fcnt == dev_n);
        adc_fmt  = (mode == MODE_MIX) ? {1'b0, adc_word[FRAME_W-2:0]} : adc_word;
        dac_next = (mode == MODE_MIX) ? {frame_word[FRAME_W-2:0], 1'b0} : frame_word;
    end

    // Outgoing word: forwarded control, local sample, or passed-through data.
    always_comb begin
        tx_load = frame_done;
        if (is_ctl && (ctl.addr != '0))
            tx_word = {ctl.flag, ctl.addr - 1'b1, ctl.idx, ctl.val};
        else if (for_me || own_data)
            tx_word = adc_fmt;
        else
            tx_word = frame_word;
    end

    // Register file update on an accepted control write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                regs[i] <= (i == 0) ? CRA_RESET : 8'h00;
            else if (wr_hit && (ctl.idx == 4'(i)))
                regs[i] <= ctl.val;
        end
    end

    // Data frame counter, restarted by register 0 writes and own frames.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcnt <= CNT_W'(1);
        else if (wr_hit && (ctl.idx == 4'd0))
            fcnt <= CNT_W'(1);
        else if (frame_done && !is_ctl)
            fcnt <= own_data ? CNT_W'(1) : fcnt + 1'b1;
    end

    // DAC register load for the frame selected by the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_load <= 1'b0;
            dac_word <= '0;
        end else begin
            dac_load <= frame_done && own_data;
            if (frame_done && own_data)
                dac_word <= dac_next;
        end
    end

    assign op_mode = mode;

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = regs[g];
    end

    // R5: data mode is left only through reset
    a_r5_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA) |=> (mode == MODE_DATA));
    // R6: frame count stays within 1 .. device count
    a_r6_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt != '0) && (fcnt <= dev_n));
    // R4: an out-of-range index leaves the register file untouched
    a_r4_idx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && for_me && !idx_ok) |=> $stable(cfg_flat));
    // R3: a forwarded control word writes nothing
    a_r3_forward_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && is_ctl && (ctl.addr != '0)) |=> $stable(cfg_flat));
    // R10: DAC load is a single-cycle pulse
    a_r10_dac_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |=> !dac_load);
endmodule

// File: rtl/codec_fi_tx.sv
// Serial transmitter: loads a word, raises the frame sync with its MSB
// and shifts it out MSB first, zeros when idle. Assumes loads are at
// least FW cycles apart.
module codec_fi_tx #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] word,
    output logic          ser_out,
    output logic          fs_out
);
    logic [FW-1:0] sr;

    // Load or shift the outgoing word; sync only with the first bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            fs_out <= 1'b0;
        end else if (load) begin
            sr     <= word;
            fs_out <= 1'b1;
        end else begin
            sr     <= {sr[FW-2:0], 1'b0};
            fs_out <= 1'b0;
        end
    end

    assign ser_out = sr[FW-1];

    // R10: outgoing sync is one cycle wide
    a_r10_fso_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fs_out |=> !fs_out);
endmodule

// File: rtl/codec_frame_if.sv
// Top of the cascaded codec frame interpreter: receiver, decision stage
// and transmitter in series. Assumes a single clock for both serial
// directions and frames of FRAME_W bits.
module codec_frame_if import codec_fi_pkg::*; #(
    parameter int NREG = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  logic                 fs_in,
    input  logic [FRAME_W-1:0]   adc_word,
    output logic                 ser_out,
    output logic                 fs_out,
    output logic [FRAME_W-1:0]   dac_word,
    output logic                 dac_load,
    output logic [1:0]           op_mode,
    output logic [NREG*8-1:0]    cfg_flat
);
    logic               done;
    logic [FRAME_W-1:0] word, adc_q, tx_word;
    logic               tx_load;

    codec_fi_rx #(.FW(FRAME_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fs_in(fs_in),
        .adc_in(adc_word), .frame_done(done), .frame_word(word),
        .adc_held(adc_q)
    );

    codec_fi_decode #(.NREG(NREG)) u_dec (
        .clk(clk), .rst_n(rst_n), .frame_done(done), .frame_word(word),
        .adc_word(adc_q), .tx_load(tx_load), .tx_word(tx_word),
        .dac_load(dac_load), .dac_word(dac_word), .op_mode(op_mode),
        .cfg_flat(cfg_flat)
    );

    codec_fi_tx #(.FW(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .word(tx_word),
        .ser_out(ser_out), .fs_out(fs_out)
    );
endmodule

// File: tb/codec_frame_if_bench.sv
module codec_frame_if_bench;
    logic        clk = 1'b0;
    logic        rst_n, ser_in, fs_in;
    logic [15:0] adc_word;
    logic        ser_out, fs_out, dac_load;
    logic [15:0] dac_word;
    logic [1:0]  op_mode;
    logic [63:0] cfg_flat;

    codec_frame_if u_codec_frame_if (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fs_in(fs_in),
        .adc_word(adc_word), .ser_out(ser_out), .fs_out(fs_out),
        .dac_word(dac_word), .dac_load(dac_load), .op_mode(op_mode),
        .cfg_flat(cfg_flat)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0, ncyc = 0, fs_cyc = 0, fso_cyc = 0, dac_cyc = 0;
    bit finished = 1'b0;
    logic [15:0] exp_tx[$], got_tx[$], exp_dac[$], got_dac[$];
    logic [7:0]  mreg [8];
    int          mcnt;
    logic [15:0] cap_w;
    int          cap_n = 0;

    always @(posedge clk) ncyc <= ncyc + 1;

    // Capture outgoing serial words and DAC loads.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fs_out) begin
                cap_w = {15'd0, ser_out}; cap_n = 1; fso_cyc = ncyc;
            end else if (cap_n != 0) begin
                cap_w = {cap_w[14:0], ser_out}; cap_n = cap_n + 1;
            end
            if (cap_n == 16) begin got_tx.push_back(cap_w); cap_n = 0; end
            if (dac_load) begin got_dac.push_back(dac_word); dac_cyc = ncyc; end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int mdev();
        return (mreg[0][6:4] == 3'd0) ? 8 : int'(mreg[0][6:4]);
    endfunction

    function automatic logic [1:0] mmode();
        if (!mreg[0][0]) return 2'd0;
        return mreg[0][1] ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [63:0] mflat();
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[i*8 +: 8] = mreg[i];
        return r;
    endfunction

    // Reference model of one frame, from the requirements.
    task automatic model(input logic [15:0] f, input logic [15:0] adc);
        logic pgm, mix;
        logic [15:0] fmt;
        pgm = !mreg[0][0];
        mix = mreg[0][0] && mreg[0][1];
        fmt = mix ? {1'b0, adc[14:0]} : adc;
        if (pgm || (mix && f[15])) begin
            if (f[14:12] != 3'd0) exp_tx.push_back({f[15], f[14:12] - 3'd1, f[11:0]});
            else begin
                exp_tx.push_back(fmt);
                if (!f[11]) begin
                    mreg[f[10:8]] = f[7:0];
                    if (f[10:8] == 3'd0) mcnt = 1;
                end
            end
        end else begin
            if (mcnt == mdev()) begin
                exp_dac.push_back(mix ? {f[14:0], 1'b0} : f);
                exp_tx.push_back(fmt);
                mcnt = 1;
            end else begin
                exp_tx.push_back(f);
                mcnt++;
            end
        end
    endtask

    task automatic send(input logic [15:0] f, input logic [15:0] adc, input int gap);
        model(f, adc);
        @(negedge clk); fs_in = 1'b1; ser_in = f[15]; adc_word = adc; fs_cyc = ncyc;
        for (int i = 14; i >= 0; i--) begin
            @(negedge clk); fs_in = 1'b0; ser_in = f[i];
        end
        repeat (gap) begin @(negedge clk); ser_in = 1'b0; fs_in = 1'b0; end
    endtask

    task automatic batch(input string req);
        @(negedge clk); ser_in = 1'b0; fs_in = 1'b0;
        repeat (40) @(negedge clk);
        chk(req, 64'(got_tx.size()), 64'(exp_tx.size()));
        for (int i = 0; i < exp_tx.size() && i < got_tx.size(); i++)
            chk(req, 64'(got_tx[i]), 64'(exp_tx[i]));
        chk(req, 64'(got_dac.size()), 64'(exp_dac.size()));
        for (int i = 0; i < exp_dac.size() && i < got_dac.size(); i++)
            chk(req, 64'(got_dac[i]), 64'(exp_dac[i]));
        chk(req, cfg_flat, mflat());
        chk(req, 64'(op_mode), 64'(mmode()));
        exp_tx.delete(); got_tx.delete(); exp_dac.delete(); got_dac.delete();
    endtask

    function automatic logic [15:0] rnd16();
        return 16'($urandom);
    endfunction

    initial begin
        logic [15:0] f;
        void'($urandom(32'd1234));
        rst_n = 1'b0; ser_in = 1'b0; fs_in = 1'b0; adc_word = 16'h0;
        for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
        mreg[0] = 8'h10; mcnt = 1;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        chk("R1", {dac_load, ser_out, fs_out}, 3'b000);
        chk("R1", 64'(dac_word), 64'h0);
        chk("R1", cfg_flat, 64'h10);
        chk("R1", 64'(op_mode), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", {dac_load, ser_out, fs_out}, 3'b000);

        // R2: addressed writes, bit 15 ignored in program mode
        send(16'h83A5, 16'hBEEF, 3);
        send(16'h0512, 16'h1357, 3);
        batch("R2");

        // R3: forwarding with decremented address
        send(16'h5377, 16'h1111, 2);
        send(16'h7FFF, 16'h2222, 0);
        send(16'h1000, 16'h3333, 2);
        for (int n = 0; n < 20; n++) begin
            f = {1'($urandom), 3'($urandom_range(1, 7)), 12'($urandom)};
            send(f, rnd16(), int'($urandom_range(0, 3)));
        end
        batch("R3");

        // R4: out-of-range indices
        send(16'h0C11, 16'h4444, 1);
        send(16'h0FEE, 16'h5555, 0);
        send(16'h08AB, 16'h6666, 1);
        batch("R4");

        // R2: random program-mode traffic, register 0 untouched
        for (int n = 0; n < 20; n++) begin
            f = {1'($urandom), 3'($urandom_range(0, 2)), 4'($urandom_range(1, 15)), 8'($urandom)};
            send(f, rnd16(), int'($urandom_range(0, 3)));
        end
        batch("R2");

        // R9: mixed mode straight from program mode
        send(16'h0013, 16'hFFFF, 2);
        batch("R9");

        // R8: random mixed-mode traffic, control and data interleaved
        for (int n = 0; n < 30; n++) begin
            if ($urandom_range(0, 1) == 1)
                f = {1'b1, 3'($urandom_range(0, 7)), 4'($urandom_range(1, 15)), 8'($urandom)};
            else
                f = {1'b0, 15'($urandom)};
            send(f, rnd16(), int'($urandom_range(0, 3)));
        end
        batch("R8");

        // R10: output and DAC timing relative to the input sync
        send(16'h1234, 16'h9ABC, 5);
        batch("R10");
        chk("R10", 64'(fso_cyc - fs_cyc), 64'd17);
        chk("R10", 64'(dac_cyc - fs_cyc), 64'd17);

        // R7 with R11: device count 3, back-to-back data frames
        send(16'h8033, 16'h0101, 0);
        for (int n = 0; n < 9; n++) send({1'b0, 15'($urandom)}, rnd16(), 0);
        batch("R11");
        // R7: field 0 means 8
        send(16'h8003, 16'h0202, 0);
        for (int n = 0; n < 16; n++) send({1'b0, 15'($urandom)}, rnd16(), 0);
        batch("R7");
        // R7: register 0 write restarts the count
        send({1'b0, 15'h1111}, 16'h0303, 1);
        send({1'b0, 15'h2222}, 16'h0404, 1);
        send(16'h8023, 16'h0505, 1);
        send({1'b0, 15'h3333}, 16'h0606, 1);
        send({1'b0, 15'h4444}, 16'h0707, 1);
        batch("R7");

        // R9: back to program mode, then a program write
        send(16'h8010, 16'h0808, 1);
        send(16'h0177, 16'h0909, 1);
        batch("R9");

        // R5: data mode locks out control frames
        send(16'h0021, 16'hA0A0, 2);
        send(16'h8003, 16'hA1A1, 0);
        send(16'h0010, 16'hA2A2, 0);
        send(16'h0310, 16'hA3A3, 0);
        batch("R5");

        // R6: random data-mode traffic, device count 2
        for (int n = 0; n < 25; n++) send(rnd16(), rnd16(), int'($urandom_range(0, 3)));
        batch("R6");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule